// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Bit Clock

This block runs one full-duplex serial transfer at a time as the master of a four-wire serial peripheral link. A single-cycle start request latches the transmit word, the character length, the rate code and the clock polarity. The block then produces a serial clock whose period comes from the rate code. It shifts the transmit word out most significant bit first and assembles the bits read from the input line into a right-justified receive word.

The rate code follows an uneven rule. Codes 0, 1 and 2 all give a four-cycle bit period. Any larger code R gives R+1 cycles. When the period is odd, the first (active) half of each bit is one cycle shorter than the second (idle) half. Only the format in which the first bit is driven before the first clock edge is supported.

Each transfer opens with one idle-level phase so that the first bit is stable before the first leading edge. When the last bit has been sampled, `busy` falls and `done` pulses for one cycle, with the serial clock already back at its idle level.

Top module: `spi_ser_master`

## Requirements
- R1: After reset, `busy`, `done` and `rx_word` are 0, and `sclk` equals `cpol`.
- R2: The bit period in `clk` cycles is 4 when `rate` is 0, 1 or 2, and `rate`+1 otherwise, up to 2^RATE_BITS.
- R3: Within a bit period P, the active phase lasts floor(P/2) cycles and the idle phase lasts the remainder. The idle phase before the first leading edge of each transfer has the idle length, because the divider restarts at every start.
- R4: The idle level of `sclk` equals `cpol`, and the active level is its inverse. A leading edge goes idle-to-active and a trailing edge goes active-to-idle.
- R5: `mosi` carries bit n-1 of `tx_word` from the cycle after the start, ahead of the first leading edge. It then advances to the next lower bit only at each later leading edge.
- R6: `miso` is sampled at every trailing edge. `rx_word` holds the n sampled bits right-justified, with the first sample in bit n-1 and all bits at n and above zero.
- R7: The character length n equals `len_sel`+1, where `len_sel` is a 4-bit field, so each transfer has exactly n leading and n trailing edges.
- R8: `done` is high for exactly one cycle, in the cycle after the final trailing edge. In that cycle `busy` is low and `rx_word` is valid. `busy` stays high for lo + n·hi + (n−1)·lo cycles.
- R9: A start while `busy` is high is ignored. Changing `tx_word`, `rate`, `len_sel` or `cpol` during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate | input | RATE_BITS | Bit-period code, latched at start |
| cpol | input | 1 | Serial clock idle level |
| len_sel | input | clog2(MAX_BITS) | Character length minus one |
| tx_word | input | MAX_BITS | Transmit word, right-justified |
| start | input | 1 | Start request, one cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | MAX_BITS | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: 16-bit words and a 7-bit rate code. This brings the longest period of 128 cycles and the full 16-bit character within reach, alongside the one-bit character. Rate codes 0, 2, 3, 4, 8, 9 and 127 cover the shared divide-by-four codes, the smallest even and odd periods, and the uneven split at odd periods. Both polarities are exercised. A start is also injected in the middle of a transfer while the transmit word is altered, to show that neither has any effect.

// File: rtl/spim_pkg.sv
// Shared types for the serial master.
// Assumes: imported by the clock generator only; no state lives here.
package spim_pkg;
    // Phase of the serial bit clock.
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,   // no transfer running
        PH_REST  = 2'd1,   // clock at idle level
        PH_DRIVE = 2'd2    // clock at active level
    } sclk_phase_e;
endpackage

// File: rtl/spim_clkgen.sv
// Bit clock generator. On launch it latches the phase lengths derived
// from the rate code and then alternates rest and drive phases, starting
// with a rest phase. It flags the leading edge (rest->drive) and the
// trailing edge (drive->rest) in the cycle before the level changes.
// Assumes: launch is only raised when no transfer is running.
module spim_clkgen #(
    parameter int RATE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              halt,
    input  logic [RATE_W-1:0] rate,
    output logic              act,
    output logic              lead,
    output logic              trail
);
    import spim_pkg::*;

    localparam int PER_W = RATE_W + 1;

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] hi_len;
    logic [PER_W-1:0] lo_len;
    logic [PER_W-1:0] hi_q;
    logic [PER_W-1:0] lo_q;
    logic [PER_W-1:0] cnt_q;
    sclk_phase_e      phase_q;

    // Period rule: codes up to 2 give four cycles, the rest give code+1.
    always_comb begin
        if (rate <= RATE_W'(2))
            period = PER_W'(4);
        else
            period = PER_W'(rate) + PER_W'(1);
        hi_len = period >> 1;
        lo_len = period - hi_len;
    end

    // Edge flags: last cycle of the current phase.
    assign lead  = (phase_q == PH_REST)  && (cnt_q == lo_q - PER_W'(1));
    assign trail = (phase_q == PH_DRIVE) && (cnt_q == hi_q - PER_W'(1));
    assign act   = (phase_q == PH_DRIVE);

    // Phase sequencer with its cycle counter, restarted at every launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            hi_q    <= PER_W'(2);
            lo_q    <= PER_W'(2);
        end else if (launch) begin
            phase_q <= PH_REST;
            cnt_q   <= '0;
            hi_q    <= hi_len;
            lo_q    <= lo_len;
        end else begin
            case (phase_q)
                PH_REST: begin
                    if (lead) begin
                        phase_q <= PH_DRIVE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + PER_W'(1);
                    end
                end
                PH_DRIVE: begin
                    if (trail) begin
                        phase_q <= halt ? PH_OFF : PH_REST;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + PER_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_OFF;
                    cnt_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
// Transfer controller. It accepts a start only when idle, counts the bits
// still to be sampled, and marks the final trailing edge. It suppresses
// the data advance at the first leading edge, because the first bit is
// already on the line by then.
// Assumes: lead and trail come from spim_clkgen and are never both high.
module spim_ctrl #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             lead,
    input  logic             trail,
    output logic             launch,
    output logic             halt,
    output logic             shift_en,
    output logic             busy,
    output logic             done
);
    logic [LEN_W-1:0] left_q;
    logic             first_q;

    assign launch   = start && !busy;
    assign halt     = trail && (left_q == '0);
    assign shift_en = lead && !first_q;

    // Busy, remaining-bit count, first-edge flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            left_q  <= '0;
            first_q <= 1'b0;
        end else if (launch) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            left_q  <= len_sel;
            first_q <= 1'b1;
        end else begin
            done <= halt;
            if (lead)
                first_q <= 1'b0;
            if (trail) begin
                if (halt)
                    busy <= 1'b0;
                else
                    left_q <= left_q - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/spim_shreg.sv
// Data path. At launch it loads the transmit word, aligned so that bit
// len_sel sits at the output, and advances it one place per shift. It
// gathers the input line at each trailing edge and publishes the
// right-justified word at the final one.
// Assumes: MAX_BITS >= 2 and LEN_W = clog2(MAX_BITS).
module spim_shreg #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                shift_en,
    input  logic                trail,
    input  logic                halt,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-2:0] rx_sh;
    logic [MAX_BITS-1:0] rx_next;
    logic [LEN_W-1:0]    align;

    assign align   = LEN_W'(MAX_BITS - 1) - len_sel;
    assign rx_next = {rx_sh, miso};
    assign mosi    = tx_q[MAX_BITS-1];

    // Transmit shifter: load aligned, advance at each later leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (launch)
            tx_q <= tx_word << align;
        else if (shift_en)
            tx_q <= tx_q << 1;
    end

    // Receive shifter: clear at launch, take one sample per trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (launch)
            rx_sh <= '0;
        else if (trail)
            rx_sh <= rx_next[MAX_BITS-2:0];
    end

    // Received word register, updated at the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_word <= '0;
        else if (halt)
            rx_word <= rx_next;
    end
endmodule

// File: rtl/spi_ser_master.sv
// Serial peripheral master, top level. It connects the controller, the bit
// clock generator and the data path, latches the polarity at start, and
// maps the internal active-level flag to the serial clock pin.
// Assumes: start is a single-cycle request; inputs are synchronous to clk.
module spi_ser_master #(
    parameter int MAX_BITS  = 16,
    parameter int RATE_BITS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [RATE_BITS-1:0]        rate,
    input  logic                        cpol,
    input  logic [$clog2(MAX_BITS)-1:0] len_sel,
    input  logic [MAX_BITS-1:0]         tx_word,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    output logic [MAX_BITS-1:0]         rx_word,
    output logic                        sclk,
    output logic                        mosi,
    input  logic                        miso
);
    localparam int LEN_W = $clog2(MAX_BITS);

    logic launch;
    logic halt;
    logic shift_en;
    logic act;
    logic lead;
    logic trail;
    logic cpol_q;

    spim_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_sel  (len_sel),
        .lead     (lead),
        .trail    (trail),
        .launch   (launch),
        .halt     (halt),
        .shift_en (shift_en),
        .busy     (busy),
        .done     (done)
    );

    spim_clkgen #(.RATE_W(RATE_BITS)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .halt   (halt),
        .rate   (rate),
        .act    (act),
        .lead   (lead),
        .trail  (trail)
    );

    spim_shreg #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .shift_en (shift_en),
        .trail    (trail),
        .halt     (halt),
        .tx_word  (tx_word),
        .len_sel  (len_sel),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    // Polarity held for the length of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpol_q <= 1'b0;
        else if (launch)
            cpol_q <= cpol;
    end

    // Pin level: live polarity when idle, latched polarity when running.
    assign sclk = busy ? (act ^ cpol_q) : cpol;
endmodule

// File: rtl/spim_checker.sv
// Temporal checks on the serial master, attached to every instance of the
// top by the bind below. Assumes cpol is held steady while busy.
module spim_checker #(
    parameter int RATE_W = 7
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cpol,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic mosi
);
    localparam int RUN_W   = RATE_W + 1;
    localparam int RUN_MAX = (1 << RATE_W) / 2 + 1;

    logic [RUN_W-1:0] run_q;

    // Length of the current constant-level stretch of sclk while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            run_q <= '0;
        else if (sclk != $past(sclk))
            run_q <= RUN_W'(1);
        else
            run_q <= run_q + RUN_W'(1);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4
    idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk == cpol));

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mosi)) |-> ((sclk != cpol) && ($past(sclk) == cpol)));

    // R3
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= RUN_W'(RUN_MAX)));
endmodule

bind spi_ser_master spim_checker #(.RATE_W(RATE_BITS)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cpol  (cpol),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi)
);

// File: tb/test_spi_ser_master.sv
// Directed bench for spi_ser_master: one task per scenario, each checking
// its own results against values derived from the requirements.
module test_spi_ser_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rate_i = '0;
    logic        cpol_i = 1'b0;
    logic [3:0]  len_i = '0;
    logic [15:0] tx_i = '0;
    logic        start_i = 1'b0;
    logic        miso_i = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] rx_word;
    logic        sclk;
    logic        mosi;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_ser_master i_spi_ser_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (rate_i),
        .cpol    (cpol_i),
        .len_sel (len_i),
        .tx_word (tx_i),
        .start   (start_i),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: state right after reset, and R4 idle level following cpol.
    task automatic t_reset;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(rx_word == 16'h0, "R1 rx_word", rx_word, 0);
        chk(sclk == cpol_i, "R1 sclk", sclk, cpol_i);
        cpol_i = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R4 idle high", sclk, 1);
        cpol_i = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R4 idle low", sclk, 0);
    endtask

    // One full transfer with a modelled slave; optional start pulse while busy.
    task automatic xfer(input int rate, input bit pol, input int nb,
                        input int tx, input int sw, input bit poke);
        int p, hi, lo, run, k, cyc, guard, got, mask, exp_cyc, last_hi, last_lo;
        bit prev, a;
        p = (rate <= 2) ? 4 : rate + 1;
        hi = p / 2;
        lo = p - hi;
        mask = (1 << nb) - 1;
        exp_cyc = lo + nb * hi + (nb - 1) * lo;
        run = 0; k = 0; cyc = 0; guard = 0; got = 0; prev = 1'b0;
        last_hi = 0; last_lo = 0;
        @(negedge clk);
        rate_i  = 7'(rate);
        cpol_i  = pol;
        len_i   = 4'(nb - 1);
        tx_i    = 16'(tx);
        miso_i  = sw[nb-1];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        tx_i    = ~16'(tx);          // R9: must not reach this transfer
        rate_i  = 7'(rate + 5);
        len_i   = 4'(nb);
        chk(busy == 1'b1, "R9 start accepted", busy, 1);
        chk(mosi == tx[nb-1], "R5 first bit before first edge", mosi, tx[nb-1]);
        forever begin
            a = sclk ^ pol;
            if (a == prev) begin
                run++;
            end else begin
                if (a) begin
                    chk(run == lo, "R3 idle phase", run, lo);
                    last_lo = run;
                end else begin
                    chk(run == hi, "R3 active phase", run, hi);
                    last_hi = run;
                    got = (got << 1) | int'(mosi);
                    k++;
                    if (k < nb) miso_i = sw[nb-1-k];
                end
                run = 1;
                prev = a;
            end
            if (!busy) break;
            cyc++;
            start_i = (poke && cyc == 3);
            guard++;
            if (guard > 5000) begin
                chk(1'b0, "R8 transfer hung", cyc, exp_cyc);
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(last_hi + last_lo == p, "R2 bit period", last_hi + last_lo, p);
        chk(done == 1'b1, "R8 done after last edge", done, 1);
        chk(cyc == exp_cyc, "R8 busy length", cyc, exp_cyc);
        chk(k == nb, "R7 bit count", k, nb);
        chk(got == (tx & mask), "R5 mosi sequence", got, tx & mask);
        chk(int'(rx_word) == (sw & mask), "R6 rx_word", rx_word, sw & mask);
        chk(sclk == pol, "R4 idle after transfer", sclk, pol);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        if (poke) begin
            repeat (8) @(negedge clk);
            chk(busy == 1'b0, "R9 no second transfer", busy, 0);
            chk(sclk == pol, "R9 clock stays idle", sclk, pol);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        xfer(0,   1'b0, 8,  'hA5,   'h3C,   1'b0);  // R2 shared code
        xfer(2,   1'b1, 8,  'h96,   'hC3,   1'b0);  // R2 shared code, R4 high idle
        xfer(3,   1'b0, 5,  'h13,   'h0B,   1'b0);  // R2 smallest code above shared
        xfer(4,   1'b0, 16, 'hBEEF, 'h1234, 1'b0);  // R3 odd period 5
        xfer(8,   1'b1, 16, 'h8001, 'hF00F, 1'b0);  // R3 odd period 9
        xfer(9,   1'b0, 1,  'h1,    'h1,    1'b0);  // R7 single bit
        xfer(9,   1'b1, 1,  'h0,    'h0,    1'b0);  // R7 single bit, zero data
        xfer(127, 1'b0, 16, 'h5AC3, 'hA5A5, 1'b0);  // R2 longest period
        xfer(6,   1'b0, 12, 'hFFF,  'h5A5,  1'b1);  // R9 start while busy
        xfer(0,   1'b1, 3,  'h5,    'h2,    1'b1);  // R9 short transfer
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule